// File: doc/BRIEF.md
# SPI Command Slave for a CAN Register File

This block is the serial front end of a CAN controller. An external host talks to it over a four-wire SPI link in mode 0. Each transaction is framed by chip select. The first byte is an opcode and any further bytes are operands or data. The block decodes the opcodes and turns them into accesses on a 128-byte register file that lives in the controller core. It also turns some opcodes into single-cycle pulses toward the core: a soft reset, per-buffer transmit requests and receive-flag clears.

The serial pins are sampled by the system clock through synchronizers, so SCK must run well below the system clock. In practice that means at least six system clocks per SCK half period.

For reads, the register file is accessed through a combinational read port. Writes go out as a one-cycle strobe that carries an address, a data byte and a bit mask. The core applies the mask itself, so a masked update needs no read-modify-write inside this block. Every burst walks a 7-bit address pointer. Three compact opcodes preset that pointer to fixed buffer locations so the host can skip the address byte.

Top module: `spi_can_cmd_slave`

## Requirements
- R1: Opcode 0xC0 produces a single-cycle `soft_reset` pulse. Any bytes that follow it in the same frame are ignored.
- R2: Opcode 0x02 is followed by a start address and then any number of data bytes. Each data byte produces one `reg_we` strobe with mask 0xFF at the current pointer, and the pointer then increments.
- R3: Opcode 0x03 is followed by a start address. The block then shifts out register bytes from successive addresses, MSB first, for as long as chip select stays low.
- R4: Opcode 0x05 is followed by an address, a mask and a data byte. It produces one strobe, with `reg_wmask` equal to the mask byte, so only the masked bits change.
- R5: Opcode 0x40|f loads transmit buffers without an address byte. Field values f = 0 to 5 preset the pointer to 0x31, 0x36, 0x41, 0x46, 0x51 and 0x56, and the data bytes that follow are written with auto-increment. Values f = 6 and 7 write nothing.
- R6: Opcode 0x80|n produces a single-cycle `tx_req` pulse equal to n[2:0]. Bit k requests transmission of buffer k, and any combination is allowed.
- R7: Opcode 0x90|(m<<1), with m = 0 to 3, reads receive buffers without an address byte. It starts the read at 0x61, 0x66, 0x71 or 0x76 respectively and then auto-increments.
- R8: When chip select rises after an R7 opcode, `rx_flag_clr` pulses for one cycle with bit m[1] set. A plain R3 read produces no such pulse.
- R9: Any opcode not listed in R1 to R7 is ignored until chip select rises: it causes no strobe and no pulse.
- R10: A rising chip select aborts any instruction in progress. A partially shifted byte is discarded, and the next frame starts with an opcode.
- R11: MOSI is sampled on SCK rising edges and MISO changes only after SCK falling edges. MISO is 0 while chip select is high.
- R12: The address pointer wraps from 0x7F to 0x00 during read and write bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| reg_raddr | output | 7 | Register file read address (the burst pointer) |
| reg_rdata | input | 8 | Register file read data, combinational from `reg_raddr` |
| reg_waddr | output | 7 | Register file write address |
| reg_wdata | output | 8 | Register file write data |
| reg_wmask | output | 8 | Bits of `reg_wdata` to apply |
| reg_we | output | 1 | Single-cycle write strobe |
| soft_reset | output | 1 | Pulse: restore register defaults |
| tx_req | output | 3 | Pulse: transmit request per buffer |
| rx_flag_clr | output | 2 | Pulse: clear a receive buffer's interrupt flag |

## Verification
The hardest case to reach from the pins is a frame torn off in the middle of a byte. To produce it, the bench shifts only a few bits of a write data byte and then raises chip select, so a half-filled shift register meets an abort. It then checks two things: no strobe was issued, and the next frame still decodes its first byte as an opcode. The receive-flag clear is also hard to observe, because it depends on how the frame ends rather than on any byte. The bench therefore closes shortcut reads and plain reads the same way and compares the pulse counts.

// File: rtl/spi_can_cmd_pkg.sv
package spi_can_cmd_pkg;

    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 8;
    localparam int NUM_TXB  = 3;
    localparam int NUM_RXB  = 2;

    localparam logic [7:0] OPC_RESET  = 8'hC0;
    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_WRITE  = 8'h02;
    localparam logic [7:0] OPC_BITMOD = 8'h05;
    localparam logic [4:0] OPC_LOADTX_HI = 5'b01000;
    localparam logic [4:0] OPC_RTS_HI    = 5'b10000;
    localparam logic [4:0] OPC_RXBUF_HI  = 5'b10010;

    localparam logic [ADDR_W-1:0] TXB_BASE = 7'h31;
    localparam logic [ADDR_W-1:0] RXB_BASE = 7'h61;
    localparam logic [ADDR_W-1:0] BUF_STRIDE = 7'h10;
    localparam logic [ADDR_W-1:0] DATA_OFS   = 7'h05;
    localparam int LOADTX_MAX = 2 * NUM_TXB - 1;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_RESET,
        OPK_READ,
        OPK_WRITE,
        OPK_BITMOD,
        OPK_LOADTX,
        OPK_RTS,
        OPK_RXBUF
    } op_kind_t;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_MASK,
        PH_BM_DATA,
        PH_WR_DATA,
        PH_RD_DATA,
        PH_IGNORE
    } phase_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] mask;
    } wr_req_t;

    function automatic op_kind_t decode_op(input logic [7:0] op);
        op_kind_t k;
        k = OPK_NONE;
        if (op == OPC_RESET)                            k = OPK_RESET;
        else if (op == OPC_READ)                        k = OPK_READ;
        else if (op == OPC_WRITE)                       k = OPK_WRITE;
        else if (op == OPC_BITMOD)                      k = OPK_BITMOD;
        else if (op[7:3] == OPC_LOADTX_HI)              k = OPK_LOADTX;
        else if (op[7:3] == OPC_RTS_HI)                 k = OPK_RTS;
        else if (op[7:3] == OPC_RXBUF_HI && !op[0])     k = OPK_RXBUF;
        return k;
    endfunction

    // Even field: header start, odd field: data start, buffer = field / 2
    function automatic logic [ADDR_W-1:0] tx_start(input logic [2:0] f);
        logic [ADDR_W-1:0] a;
        a = TXB_BASE + (ADDR_W'(f[2:1]) * BUF_STRIDE);
        if (f[0]) a = a + DATA_OFS;
        return a;
    endfunction

    function automatic logic [ADDR_W-1:0] rx_start(input logic [1:0] m);
        logic [ADDR_W-1:0] a;
        a = RXB_BASE + (ADDR_W'(m[1]) * BUF_STRIDE);
        if (m[0]) a = a + DATA_OFS;
        return a;
    endfunction

endpackage

// File: rtl/spi_can_pin_sync.sv
module spi_can_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_active,
    output logic cs_rise,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_sr, cs_sr, mosi_sr;
    logic sck_d, cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sr  <= '0;
            cs_sr   <= '1;
            mosi_sr <= '0;
            sck_d   <= 1'b0;
            cs_d    <= 1'b1;
        end else begin
            sck_sr  <= {sck_sr[STAGES-2:0], sck};
            cs_sr   <= {cs_sr[STAGES-2:0], cs_n};
            mosi_sr <= {mosi_sr[STAGES-2:0], mosi};
            sck_d   <= sck_sr[STAGES-1];
            cs_d    <= cs_sr[STAGES-1];
        end
    end

    assign sck_rise  = sck_sr[STAGES-1] & ~sck_d;
    assign sck_fall  = ~sck_sr[STAGES-1] & sck_d;
    assign cs_active = ~cs_sr[STAGES-1];
    assign cs_rise   = cs_sr[STAGES-1] & ~cs_d;
    assign mosi_s    = mosi_sr[STAGES-1];
endmodule

// File: rtl/spi_can_shifter.sv
module spi_can_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_active,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_byte,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_out,
    output logic              miso
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst || !cs_active) begin
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            byte_valid <= 1'b0;
            byte_out   <= '0;
            miso       <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (sck_rise) begin
                rx_sh <= {rx_sh[DATA_W-2:0], mosi_s};
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt    <= '0;
                    byte_valid <= 1'b1;
                    byte_out   <= {rx_sh[DATA_W-2:0], mosi_s};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (sck_fall) begin
                if (bit_cnt == '0) begin
                    miso  <= load_en & load_byte[DATA_W-1];
                    tx_sh <= load_en ? {load_byte[DATA_W-2:0], 1'b0} : '0;
                end else begin
                    miso  <= tx_sh[DATA_W-1];
                    tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_can_decoder.sv
module spi_can_decoder
    import spi_can_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              cs_rise,
    output logic [ADDR_W-1:0] ptr,
    output logic              rd_phase,
    output wr_req_t           wr,
    output logic              soft_reset,
    output logic [NUM_TXB-1:0] tx_req,
    output logic [NUM_RXB-1:0] rx_flag_clr
);
    phase_t   phase;
    op_kind_t cmd;
    op_kind_t kind;
    logic [DATA_W-1:0] mask_q;
    logic              rxb_pending;
    logic              rxb_sel;

    assign kind     = decode_op(byte_in);
    assign rd_phase = (phase == PH_RD_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_OPCODE;
            cmd         <= OPK_NONE;
            ptr         <= '0;
            mask_q      <= '0;
            rxb_pending <= 1'b0;
            rxb_sel     <= 1'b0;
            wr          <= '0;
            soft_reset  <= 1'b0;
            tx_req      <= '0;
            rx_flag_clr <= '0;
        end else begin
            wr.we       <= 1'b0;
            soft_reset  <= 1'b0;
            tx_req      <= '0;
            rx_flag_clr <= '0;
            if (cs_rise) begin
                phase <= PH_OPCODE;
                if (rxb_pending) rx_flag_clr[rxb_sel] <= 1'b1;
                rxb_pending <= 1'b0;
            end else if (byte_valid) begin
                unique case (phase)
                    PH_OPCODE: begin
                        cmd <= kind;
                        unique case (kind)
                            OPK_RESET: begin
                                soft_reset <= 1'b1;
                                phase      <= PH_IGNORE;
                            end
                            OPK_READ, OPK_WRITE, OPK_BITMOD: phase <= PH_ADDR;
                            OPK_LOADTX: begin
                                if (int'(byte_in[2:0]) <= LOADTX_MAX) begin
                                    ptr   <= tx_start(byte_in[2:0]);
                                    phase <= PH_WR_DATA;
                                end else begin
                                    phase <= PH_IGNORE;
                                end
                            end
                            OPK_RTS: begin
                                tx_req <= byte_in[NUM_TXB-1:0];
                                phase  <= PH_IGNORE;
                            end
                            OPK_RXBUF: begin
                                ptr         <= rx_start(byte_in[2:1]);
                                rxb_pending <= 1'b1;
                                rxb_sel     <= byte_in[2];
                                phase       <= PH_RD_DATA;
                            end
                            default: phase <= PH_IGNORE;
                        endcase
                    end
                    PH_ADDR: begin
                        ptr <= byte_in[ADDR_W-1:0];
                        if (cmd == OPK_READ)       phase <= PH_RD_DATA;
                        else if (cmd == OPK_WRITE) phase <= PH_WR_DATA;
                        else                       phase <= PH_MASK;
                    end
                    PH_MASK: begin
                        mask_q <= byte_in;
                        phase  <= PH_BM_DATA;
                    end
                    PH_BM_DATA: begin
                        wr    <= '{we: 1'b1, addr: ptr, data: byte_in, mask: mask_q};
                        phase <= PH_IGNORE;
                    end
                    PH_WR_DATA: begin
                        wr  <= '{we: 1'b1, addr: ptr, data: byte_in, mask: '1};
                        ptr <= ptr + ADDR_W'(1);
                    end
                    PH_RD_DATA: ptr <= ptr + ADDR_W'(1);
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_can_cmd_slave.sv
module spi_can_cmd_slave
    import spi_can_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               mosi,
    output logic               miso,
    output logic [ADDR_W-1:0]  reg_raddr,
    input  logic [DATA_W-1:0]  reg_rdata,
    output logic [ADDR_W-1:0]  reg_waddr,
    output logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_wmask,
    output logic               reg_we,
    output logic               soft_reset,
    output logic [NUM_TXB-1:0] tx_req,
    output logic [NUM_RXB-1:0] rx_flag_clr
);
    logic sck_rise, sck_fall, cs_active, cs_rise, mosi_s;
    logic byte_valid, rd_phase;
    logic [DATA_W-1:0] byte_val;
    wr_req_t wr;

    spi_can_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_active(cs_active),
        .cs_rise(cs_rise), .mosi_s(mosi_s)
    );

    spi_can_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .cs_active(cs_active),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
        .load_en(rd_phase), .load_byte(reg_rdata),
        .byte_valid(byte_valid), .byte_out(byte_val), .miso(miso)
    );

    spi_can_decoder u_dec (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_val),
        .cs_rise(cs_rise), .ptr(reg_raddr), .rd_phase(rd_phase), .wr(wr),
        .soft_reset(soft_reset), .tx_req(tx_req), .rx_flag_clr(rx_flag_clr)
    );

    assign reg_we    = wr.we;
    assign reg_waddr = wr.addr;
    assign reg_wdata = wr.data;
    assign reg_wmask = wr.mask;
endmodule

// File: rtl/spi_can_cmd_checker.sv
module spi_can_cmd_checker
    import spi_can_cmd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               miso,
    input logic               cs_active,
    input logic               cs_rise,
    input logic               reg_we,
    input logic               soft_reset,
    input logic [NUM_TXB-1:0] tx_req,
    input logic [NUM_RXB-1:0] rx_flag_clr
);
    a_r1_srst_single: assert property (@(posedge clk) disable iff (rst)
        soft_reset |=> !soft_reset);

    a_r2_we_single: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    a_r6_txreq_single: assert property (@(posedge clk) disable iff (rst)
        (tx_req != '0) |=> (tx_req == '0));

    a_r8_rxclr_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rx_flag_clr));

    a_r8_rxclr_after_cs: assert property (@(posedge clk) disable iff (rst)
        (rx_flag_clr != '0) |-> $past(cs_rise));

    a_r11_miso_quiet: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> !miso);
endmodule

bind spi_can_cmd_slave spi_can_cmd_checker u_chk (
    .clk(clk), .rst(rst), .miso(miso), .cs_active(cs_active),
    .cs_rise(cs_rise), .reg_we(reg_we), .soft_reset(soft_reset),
    .tx_req(tx_req), .rx_flag_clr(rx_flag_clr)
);

// File: tb/spi_can_cmd_slave_test.sv
module spi_can_cmd_slave_test;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [6:0] reg_raddr, reg_waddr;
    logic [7:0] reg_rdata, reg_wdata, reg_wmask;
    logic reg_we, soft_reset;
    logic [2:0] tx_req;
    logic [1:0] rx_flag_clr;

    always #5 clk = ~clk;

    spi_can_cmd_slave uut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_we(reg_we),
        .soft_reset(soft_reset), .tx_req(tx_req), .rx_flag_clr(rx_flag_clr)
    );

    // Core-side register file model
    logic [7:0] mem [128];
    int cnt_we, cnt_tx, cnt_rx, cnt_srst;
    logic [2:0] last_tx;
    logic [1:0] last_rx;

    assign reg_rdata = mem[reg_raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) mem[i] <= 8'h00;
            cnt_we <= 0; cnt_tx <= 0; cnt_rx <= 0; cnt_srst <= 0;
            last_tx <= '0; last_rx <= '0;
        end else begin
            if (soft_reset) begin
                for (int i = 0; i < 128; i++) mem[i] <= 8'h00;
                cnt_srst <= cnt_srst + 1;
            end else if (reg_we) begin
                mem[reg_waddr] <= (mem[reg_waddr] & ~reg_wmask) | (reg_wdata & reg_wmask);
                cnt_we <= cnt_we + 1;
            end
            if (tx_req != '0) begin cnt_tx <= cnt_tx + 1; last_tx <= tx_req; end
            if (rx_flag_clr != '0) begin cnt_rx <= cnt_rx + 1; last_rx <= rx_flag_clr; end
        end
    end

    int vectors = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_lo();
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_hi();
        @(negedge clk) begin sck = 1'b0; cs_n = 1'b1; end
        repeat (12) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic wr2(input logic [6:0] a, input logic [7:0] d0, input logic [7:0] d1);
        logic [7:0] r;
        cs_lo();
        xfer(8'h02, r); xfer({1'b0, a}, r); xfer(d0, r); xfer(d1, r);
        cs_hi();
    endtask

    task automatic rd2(input logic [6:0] a, output logic [7:0] q0, output logic [7:0] q1);
        logic [7:0] r;
        cs_lo();
        xfer(8'h03, r); xfer({1'b0, a}, r); xfer(8'h00, q0); xfer(8'h00, q1);
        cs_hi();
    endtask

    typedef struct packed {
        logic [6:0] addr;
        logic [7:0] d0;
        logic [7:0] d1;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{7'h28, 8'h03, 8'hB9},
        '{7'h2A, 8'h85, 8'hFF},
        '{7'h00, 8'h5A, 8'hA5},
        '{7'h10, 8'h01, 8'h80},
        '{7'h3E, 8'hC3, 8'h3C},
        '{7'h60, 8'h7E, 8'h00}
    };

    initial begin
        logic [7:0] q0, q1, r;
        int base_we, base_rx;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // Reset state
        chk("R11 miso idle after reset", miso, 0);
        chk("R2 no strobe after reset", cnt_we, 0);
        chk("R6 no tx request after reset", cnt_tx, 0);

        // Table: write burst then read burst (R2, R3)
        for (int k = 0; k < NV; k++) begin
            wr2(VECS[k].addr, VECS[k].d0, VECS[k].d1);
            rd2(VECS[k].addr, q0, q1);
            chk("R2/R3 burst byte0", q0, VECS[k].d0);
            chk("R2/R3 burst byte1", q1, VECS[k].d1);
        end

        // R11: MISO low after a read that ended on a one bit
        wr2(7'h50, 8'hFF, 8'hFF);
        cs_lo(); xfer(8'h03, r); xfer(8'h50, r); xfer(8'h00, q0); cs_hi();
        chk("R11 read data", q0, 8'hFF);
        chk("R11 miso idle after frame", miso, 0);

        // R12: wrap in write and read bursts
        wr2(7'h7F, 8'h5A, 8'h6B);
        chk("R12 wrap write top", mem[127], 8'h5A);
        chk("R12 wrap write bottom", mem[0], 8'h6B);
        rd2(7'h7F, q0, q1);
        chk("R12 wrap read top", q0, 8'h5A);
        chk("R12 wrap read bottom", q1, 8'h6B);

        // R4: bit-modify
        wr2(7'h20, 8'hF0, 8'h00);
        cs_lo(); xfer(8'h05, r); xfer(8'h20, r); xfer(8'h3C, r); xfer(8'hAA, r); cs_hi();
        rd2(7'h20, q0, q1);
        chk("R4 masked update", q0, 8'hE8);
        chk("R4 neighbour untouched", q1, 8'h00);

        // R5: load transmit buffer shortcuts
        for (int f = 0; f < 6; f++) begin
            logic [6:0] a;
            a = 7'h31 + 7'(f / 2) * 7'h10 + ((f % 2) != 0 ? 7'd5 : 7'd0);
            cs_lo(); xfer(8'h40 | 8'(f), r); xfer(8'hB0 + 8'(f), r); xfer(8'hC0 + 8'(f), r); cs_hi();
            rd2(a, q0, q1);
            chk("R5 load start byte", q0, 8'hB0 + f);
            chk("R5 load next byte", q1, 8'hC0 + f);
        end
        base_we = cnt_we;
        cs_lo(); xfer(8'h46, r); xfer(8'hEE, r); cs_hi();
        cs_lo(); xfer(8'h47, r); xfer(8'hEE, r); cs_hi();
        chk("R5 field 6/7 writes nothing", cnt_we, base_we);

        // R6: request to send
        cs_lo(); xfer(8'h85, r); cs_hi();
        chk("R6 tx_req 101", last_tx, 3'b101);
        cs_lo(); xfer(8'h82, r); cs_hi();
        chk("R6 tx_req 010", last_tx, 3'b010);
        chk("R6 pulse count", cnt_tx, 2);

        // R7 / R8: receive buffer shortcuts
        wr2(7'h76, 8'hA5, 8'h3C);
        base_rx = cnt_rx;
        cs_lo(); xfer(8'h96, r); xfer(8'h00, q0); xfer(8'h00, q1); cs_hi();
        chk("R7 rxb m=3 byte0", q0, 8'hA5);
        chk("R7 rxb m=3 byte1", q1, 8'h3C);
        chk("R8 clear count m=3", cnt_rx, base_rx + 1);
        chk("R8 clear buffer1", last_rx, 2'b10);
        wr2(7'h61, 8'h11, 8'h22);
        cs_lo(); xfer(8'h90, r); xfer(8'h00, q0); cs_hi();
        chk("R7 rxb m=0 byte0", q0, 8'h11);
        chk("R8 clear buffer0", last_rx, 2'b01);
        wr2(7'h71, 8'h44, 8'h00);
        cs_lo(); xfer(8'h94, r); xfer(8'h00, q0); cs_hi();
        chk("R7 rxb m=2 byte0", q0, 8'h44);
        chk("R8 clear buffer1 via m=2", last_rx, 2'b10);
        base_rx = cnt_rx;
        rd2(7'h61, q0, q1);
        chk("R8 plain read no clear", cnt_rx, base_rx);

        // R9: unknown opcode
        base_we = cnt_we; base_rx = cnt_tx;
        cs_lo(); xfer(8'h77, r); xfer(8'h10, r); xfer(8'h99, r); cs_hi();
        chk("R9 unknown no strobe", cnt_we, base_we);
        chk("R9 unknown no tx pulse", cnt_tx, base_rx);

        // R10: abort in the middle of a data byte
        wr2(7'h12, 8'h33, 8'h44);
        base_we = cnt_we;
        cs_lo(); xfer(8'h02, r); xfer(8'h12, r); xbits(8'hFF, 4, r); cs_hi();
        chk("R10 partial byte discarded", cnt_we, base_we);
        rd2(7'h12, q0, q1);
        chk("R10 old value kept", q0, 8'h33);
        chk("R10 next frame decodes opcode", q1, 8'h44);

        // R1: soft reset, trailing bytes ignored
        base_we = cnt_we;
        cs_lo(); xfer(8'hC0, r); xfer(8'h02, r); xfer(8'h12, r); xfer(8'h55, r); cs_hi();
        chk("R1 reset pulse count", cnt_srst, 1);
        chk("R1 trailing bytes ignored", cnt_we, base_we);
        rd2(7'h12, q0, q1);
        chk("R1 register back to default", q0, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule